// File: doc/BRIEF.md
# Integer ALU with Compare

A registered 64-bit integer arithmetic unit with two operand inputs and one result output. One shared adder serves addition, subtraction and every compare: for subtraction and compares the second operand is bit-inverted and the carry into the adder is forced to 1. The logical operations AND, OR and XOR run beside the adder.

A compare subtracts the operands and derives four internal conditions from the difference: zero, carry out, sign and signed overflow. It returns 0 or 1 as a 64-bit register value. The conditions are never exposed. Less-than and less-or-equal have no opcodes of their own; the caller swaps the operands of greater-than or greater-or-equal.

A width control selects how an arithmetic or logical result is written: the full 64 bits, the low 32 bits sign-extended, or the low 32 bits zero-extended. The result and a valid flag appear one clock after a valid input.

Top module: `int_alu`

## Requirements
- R1: Opcode encoding on `op_i[3:0]` is 0=ADD, 1=SUB, 2=AND, 3=OR, 4=XOR, 5=EQ, 6=NE, 7=signed GT, 8=signed GE, 9=unsigned GT, 10=unsigned GE. Codes 11 to 15 give a result of 0.
- R2: ADD returns a+b modulo 2^64, and SUB returns a-b modulo 2^64.
- R3: AND, OR and XOR return the bitwise function of the two operands.
- R4: EQ returns 1 when a==b, and NE returns 1 when a!=b.
- R5: Signed GT and signed GE compare the operands as two's-complement numbers, and stay correct when the subtraction overflows.
- R6: Unsigned GT and unsigned GE compare the operands as unsigned numbers.
- R7: The width code `ext_i` selects the result form for non-compare ops: 0 = full 64 bits, 1 = low 32 bits sign-extended, 2 = low 32 bits zero-extended, 3 = full 64 bits.
- R8: A compare result always has bits 63:1 equal to 0, whatever the width code.
- R9: `res_o` and `vld_o` update on the clock edge after the input is presented. A cycle with `vld_i` low gives `vld_o` low on the next edge and leaves `res_o` unchanged.
- R10: An active-low reset `rst_n` clears `res_o` to 0 and `vld_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vld_i | input | 1 | Input operation valid |
| op_i | input | 4 | Operation code |
| ext_i | input | 2 | Result width code |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| vld_o | output | 1 | Result valid |
| res_o | output | 64 | Registered result |

## Verification
The operands include equal values, values at the signed extremes, and pairs whose subtraction overflows. The signed and unsigned orderings disagree on these pairs, so they show whether the greater-than conditions use the overflow and carry terms correctly. Operands with bit 31 set and clear, run under each width code, tell sign extension apart from zero extension and from the full 64-bit pass. Compares under all width codes confirm that the upper bits stay clear. Random operands, with idle cycles in between, cover the remaining cases and the valid-hold behaviour.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR = 4'd3,
        OP_XOR = 4'd4, OP_EQ = 4'd5, OP_NE = 4'd6, OP_SGT = 4'd7,
        OP_SGE = 4'd8, OP_UGT = 4'd9, OP_UGE = 4'd10
    } alu_op_e;

    typedef enum logic [1:0] {
        EXT_FULL = 2'd0, EXT_SIGN = 2'd1, EXT_ZERO = 2'd2, EXT_FULL2 = 2'd3
    } ext_e;

    typedef struct packed {
        logic zf;
        logic cf;
        logic sf;
        logic of;
    } cond_t;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output int_alu_pkg::cond_t cond_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff       = sub_i ? ~b_i : b_i;
        wide        = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
        sum_o       = wide[W-1:0];
        cond_o.zf   = (wide[W-1:0] == '0);
        cond_o.cf   = wide[W];
        cond_o.sf   = wide[W-1];
        cond_o.of   = (a_i[W-1] == b_eff[W-1]) && (wide[W-1] != a_i[W-1]);
    end

    // R2: in subtract mode a zero difference implies carry out (no borrow)
    always_comb begin
        if (sub_i && cond_o.zf) begin
            assert_zero_has_carry_R2: assert (cond_o.cf)
                else $error("zero difference without carry");
        end
    end
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp (
    input  int_alu_pkg::alu_op_e op_i,
    input  int_alu_pkg::cond_t   cond_i,
    output logic                 bit_o,
    output logic                 is_cmp_o
);
    import int_alu_pkg::*;
    logic s_eq_o;

    always_comb begin
        s_eq_o   = (cond_i.sf == cond_i.of);
        is_cmp_o = 1'b1;
        bit_o    = 1'b0;
        unique case (op_i)
            OP_EQ:   bit_o = cond_i.zf;
            OP_NE:   bit_o = !cond_i.zf;
            OP_SGT:  bit_o = !cond_i.zf && s_eq_o;
            OP_SGE:  bit_o = s_eq_o;
            OP_UGT:  bit_o = cond_i.cf && !cond_i.zf;
            OP_UGE:  bit_o = cond_i.cf;
            default: is_cmp_o = 1'b0;
        endcase
    end

    // R4/R5/R6: a strict greater never holds together with equality
    always_comb begin
        if (is_cmp_o && cond_i.zf && (op_i == OP_SGT || op_i == OP_UGT)) begin
            assert_gt_excl_eq_R5: assert (!bit_o)
                else $error("greater-than true on equal operands");
        end
    end
endmodule

// File: rtl/alu_extend.sv
module alu_extend #(
    parameter int W  = 64,
    parameter int HW = 32
) (
    input  logic [W-1:0]       val_i,
    input  int_alu_pkg::ext_e  ext_i,
    output logic [W-1:0]       val_o
);
    import int_alu_pkg::*;
    always_comb begin
        unique case (ext_i)
            EXT_SIGN: val_o = {{(W-HW){val_i[HW-1]}}, val_i[HW-1:0]};
            EXT_ZERO: val_o = {{(W-HW){1'b0}}, val_i[HW-1:0]};
            default:  val_o = val_i;
        endcase
    end
endmodule

// File: rtl/int_alu.sv
module int_alu #(
    parameter int W  = 64,
    parameter int HW = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [3:0]   op_i,
    input  logic [1:0]   ext_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         vld_o,
    output logic [W-1:0] res_o
);
    import int_alu_pkg::*;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
    } state_t;

    state_t   st_d, st_q;
    alu_op_e  op;
    logic     sub_en;
    logic [W-1:0] sum;
    cond_t    cond;
    logic     cmp_bit, is_cmp;
    logic [W-1:0] raw, ext_val;

    assign op     = alu_op_e'(op_i);
    assign sub_en = (op != OP_ADD);

    alu_adder #(.W(W)) u_add (
        .a_i(a_i), .b_i(b_i), .sub_i(sub_en), .sum_o(sum), .cond_o(cond)
    );

    alu_cmp u_cmp (
        .op_i(op), .cond_i(cond), .bit_o(cmp_bit), .is_cmp_o(is_cmp)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB: raw = sum;
            OP_AND:         raw = a_i & b_i;
            OP_OR:          raw = a_i | b_i;
            OP_XOR:         raw = a_i ^ b_i;
            default:        raw = '0;
        endcase
    end

    alu_extend #(.W(W), .HW(HW)) u_ext (
        .val_i(raw), .ext_i(ext_e'(ext_i)), .val_o(ext_val)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.res = is_cmp ? {{(W-1){1'b0}}, cmp_bit} : ext_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign res_o = st_q.res;

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (vld_o == $past(vld_i)));
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(res_o));
    assert_cmp_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && op_i >= 4'd5 && op_i <= 4'd10) |=> (res_o[W-1:1] == '0));
    assert_zext_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && op_i <= 4'd4 && ext_i == 2'd2) |=> (res_o[W-1:HW] == '0));
endmodule

// File: tb/int_alu_tb.sv
module int_alu_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        vld_i = 0;
    logic [3:0]  op_i = 0;
    logic [1:0]  ext_i = 0;
    logic [63:0] a_i = 0, b_i = 0;
    logic        vld_o;
    logic [63:0] res_o;

    int checks = 0, fails = 0;
    logic [63:0] exp_res = 0;

    always #4 clk = ~clk;

    int_alu u_dut (.clk(clk), .rst_n(rst_n), .vld_i(vld_i), .op_i(op_i),
        .ext_i(ext_i), .a_i(a_i), .b_i(b_i), .vld_o(vld_o), .res_o(res_o));

    function automatic logic [63:0] model(input logic [3:0] op, input logic [1:0] ex,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        logic signed [63:0] sa, sb;
        sa = a; sb = b;
        case (op)
            0: r = a + b;
            1: r = a - b;
            2: r = a & b;
            3: r = a | b;
            4: r = a ^ b;
            5: return {63'd0, a == b};
            6: return {63'd0, a != b};
            7: return {63'd0, sa > sb};
            8: return {63'd0, sa >= sb};
            9: return {63'd0, a > b};
            10: return {63'd0, a >= b};
            default: return 64'd0;
        endcase
        if (ex == 1) r = {{32{r[31]}}, r[31:0]};
        else if (ex == 2) r = {32'd0, r[31:0]};
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive after negedge, sample at next negedge (one edge later)
    task automatic run(input string req, input logic [3:0] op, input logic [1:0] ex,
                       input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        vld_i = 1; op_i = op; ext_i = ex; a_i = a; b_i = b;
        exp_res = model(op, ex, a, b);
        @(negedge clk);
        vld_i = 0;
        chk(req, res_o, exp_res);
        chk({req, " R9 valid"}, {63'd0, vld_o}, 64'd1);
    endtask

    localparam logic [63:0] MINS = 64'h8000_0000_0000_0000;
    localparam logic [63:0] MAXS = 64'h7FFF_FFFF_FFFF_FFFF;

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1;
        chk("R10 reset res", res_o, 0);
        chk("R10 reset vld", {63'd0, vld_o}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R2
        run("R2 add", 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
        run("R2 sub", 1, 0, 64'd3, 64'd5);
        // R3
        run("R3 and", 2, 0, 64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_FFFF);
        run("R3 or",  3, 0, 64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_FFFF);
        run("R3 xor", 4, 0, 64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_FFFF);
        // R4
        run("R4 eq", 5, 0, 64'd42, 64'd42);
        run("R4 eq0", 5, 0, 64'd42, 64'd43);
        run("R4 ne", 6, 0, 64'd42, 64'd43);
        // R5 overflow pairs
        run("R5 sgt ovf", 7, 0, MAXS, MINS);
        run("R5 sgt ovf2", 7, 0, MINS, MAXS);
        run("R5 sge eq", 8, 0, MINS, MINS);
        run("R5 sgt eq", 7, 0, 64'd9, 64'd9);
        run("R5 sgt neg", 7, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
        // R6
        run("R6 ugt", 9, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
        run("R6 ugt eq", 9, 0, 64'd7, 64'd7);
        run("R6 uge eq", 10, 0, 64'd7, 64'd7);
        run("R6 uge lt", 10, 0, 64'd6, 64'd7);
        // R7
        for (int e = 0; e < 4; e++) begin
            run("R7 ext add", 0, e[1:0], 64'h1234_5678_7FFF_FFFF, 64'd1);
            run("R7 ext or", 3, e[1:0], 64'hABCD_0000_0000_0001, 64'h0000_0000_0000_0010);
        end
        // R8
        for (int e = 0; e < 4; e++) run("R8 cmp ext", 10, e[1:0], 64'd5, 64'd1);
        // R1 unused codes
        for (int o = 11; o < 16; o++) run("R1 unused op", o[3:0], 0, 64'd5, 64'd9);
        // R9 hold on idle
        run("R9 set", 0, 0, 64'd100, 64'd23);
        @(negedge clk);
        a_i = 64'd999; op_i = 4'd1;
        @(negedge clk);
        chk("R9 idle hold", res_o, 64'd123);
        chk("R9 idle vld", {63'd0, vld_o}, 0);
        // random
        for (int i = 0; i < 400; i++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom}; rb = (i % 5 == 0) ? ra : {$urandom, $urandom};
            if (i % 7 == 0) rb[63] = ~ra[63];
            run("R1 random", 4'($urandom_range(0, 10)), 2'($urandom_range(0, 3)), ra, rb);
        end
        // R10 reset mid-run
        run("R10 pre", 0, 0, 64'd1, 64'd1);
        rst_n = 0;
        #1;
        chk("R10 async res", res_o, 0);
        chk("R10 async vld", {63'd0, vld_o}, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule